// File: doc/BRIEF.md
# PHY Management Interface Master

This block talks to one external Ethernet PHY over the two-wire management bus. It derives the management clock from the system clock, drives the bidirectional data line through separate output, output-enable and input pins, and carries out single register read and write frames addressed to one fixed PHY address. A host issues a request with a three-bit command code and waits on `busy`; a one-clock `done` marks completion, with any read result already on `rd_data`.

Besides raw register access, three helper commands run the usual bring-up tasks. A soft reset writes the reset bit to the control register and then keeps the block busy for a settle interval. A link query reads the status register and exposes its link bit on `link_up`. A link-mode command writes the control register with either autonegotiation enabled or a forced speed and duplex.

Top module: `phy_mgmt_master`

## Requirements
- R1: While and right after reset, `busy`, `done`, `mdc`, `mdio_oe`, `link_up` are 0 and `rd_data` is 0.
- R2: During a frame each high phase and each low phase of `mdc` between high phases lasts exactly CLK_HALF system clocks; `mdc` is low whenever `busy` is low.
- R3: A write frame (command 1) has 65 management clock cycles, all driven: 32 ones, start/opcode 0101, PHY address (5 bits), register address (5 bits), turnaround 1 then 0, 16 data bits, one idle cycle at 1; every field MSB first.
- R4: A read frame (command 0) has 64 cycles: 32 ones, 0110, PHY address, register address driven; then the line is released for one turnaround cycle and 16 data cycles, the data bits sampled MSB first on the falling edge that ends each cycle, then one driven idle cycle at 1. The sampled word appears on `rd_data` with `done`.
- R5: `mdio_oe` is 0 whenever `busy` is 0.
- R6: `mdio_o` and `mdio_oe` change only while `mdc` is low.
- R7: Command 2 writes 0x8000 to register 0, then keeps `busy` high for SETTLE_CYCLES further clocks before `done`.
- R8: Command 3 reads register 1; `rd_data` gets the whole word and `link_up` gets its bit 2, held until the next command 3.
- R9: Command 4 writes register 0 with a word chosen by `req_mode`: 0 autonegotiate gives 0x1000 (bit 12), 1 gives 0x0000 (10 Mb/s half), 2 gives 0x0100 (10 Mb/s full, bit 8), 3 gives 0x2000 (100 Mb/s half, bit 13), 4 gives 0x2100 (100 Mb/s full); codes 5 to 7 act as autonegotiate.
- R10: A request while `busy` is high, or with command code 5, 6 or 7, is ignored and starts no frame.
- R11: `done` is high for exactly one clock, in which `busy` is already low; `rd_data` changes only in a clock where `done` is high and only after a read-type command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_cmd | input | 3 | 0 read, 1 write, 2 PHY reset, 3 link query, 4 link mode |
| req_reg | input | 5 | Register address for raw read or write |
| req_wdata | input | 16 | Data for raw write |
| req_mode | input | 3 | Link mode for command 4 |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Last word read from the PHY |
| link_up | output | 1 | Link bit from the last link query |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data line as seen at the pin |

## Verification
The hardest condition to reach from the ports is a second request landing in the middle of a frame, because the host normally waits on `busy`. The bench raises a conflicting request well inside a running frame and then confirms the captured frame still matches the first command and no further management clock edges follow. A bench-side PHY model records every rising management clock edge and answers reads with random words, so field order, release window and sample timing are all checked against a frame built independently by bench functions.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [2:0] {
        CMD_RAW_READ   = 3'd0,
        CMD_RAW_WRITE  = 3'd1,
        CMD_PHY_RESET  = 3'd2,
        CMD_LINK_QUERY = 3'd3,
        CMD_LINK_MODE  = 3'd4
    } mgmt_cmd_e;

    // register addresses and bit positions the PHY decodes
    localparam logic [4:0] REG_CONTROL = 5'd0;
    localparam logic [4:0] REG_STATUS  = 5'd1;
    localparam int BIT_SOFT_RESET = 15;
    localparam int BIT_SPEED_100  = 13;
    localparam int BIT_AUTONEG    = 12;
    localparam int BIT_FULL_DUP   = 8;
    localparam int BIT_LINK_OK    = 2;

    typedef struct packed {
        logic        valid;
        logic        is_read;
        logic        settle;
        logic        query;
        logic [4:0]  regad;
        logic [15:0] data;
    } frame_req_t;

endpackage

// File: rtl/mdio_cmd_map.sv
module mdio_cmd_map
    import mdio_pkg::*;
(
    input  logic [2:0]  cmd,
    input  logic [4:0]  regad,
    input  logic [15:0] wdata,
    input  logic [2:0]  mode,
    output frame_req_t  req
);
    logic [15:0] mode_word;

    always_comb begin
        mode_word = '0;
        case (mode)
            3'd1: mode_word = '0;
            3'd2: mode_word[BIT_FULL_DUP] = 1'b1;
            3'd3: mode_word[BIT_SPEED_100] = 1'b1;
            3'd4: begin
                mode_word[BIT_SPEED_100] = 1'b1;
                mode_word[BIT_FULL_DUP]  = 1'b1;
            end
            default: mode_word[BIT_AUTONEG] = 1'b1;
        endcase
    end

    always_comb begin
        req = '0;
        case (cmd)
            CMD_RAW_READ: begin
                req.valid = 1'b1; req.is_read = 1'b1; req.regad = regad;
            end
            CMD_RAW_WRITE: begin
                req.valid = 1'b1; req.regad = regad; req.data = wdata;
            end
            CMD_PHY_RESET: begin
                req.valid = 1'b1; req.settle = 1'b1; req.regad = REG_CONTROL;
                req.data[BIT_SOFT_RESET] = 1'b1;
            end
            CMD_LINK_QUERY: begin
                req.valid = 1'b1; req.is_read = 1'b1; req.query = 1'b1;
                req.regad = REG_STATUS;
            end
            CMD_LINK_MODE: begin
                req.valid = 1'b1; req.regad = REG_CONTROL; req.data = mode_word;
            end
            default: req = '0;
        endcase
    end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine #(
    parameter int         CLK_HALF = 40,
    parameter logic [4:0] PHY_ADDR = 5'h07
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        is_read,
    input  logic [4:0]  regad,
    input  logic [15:0] wdata,
    input  logic        mdio_i,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        frame_done,
    output logic [15:0] rx_data
);
    localparam int CW = $clog2(CLK_HALF + 1);
    localparam logic [CW-1:0] HALF_LAST = CW'(CLK_HALF - 1);
    localparam logic [6:0] TA_BIT     = 7'd46;
    localparam logic [6:0] DATA_FIRST = 7'd47;
    localparam logic [6:0] DATA_LAST  = 7'd62;
    localparam logic [6:0] RD_END     = 7'd63;
    localparam logic [6:0] WR_END     = 7'd64;

    typedef struct packed {
        logic          active;
        logic          clk_lvl;
        logic          rd;
        logic          fdone;
        logic [CW-1:0] cnt;
        logic [6:0]    bitn;
        logic [63:0]   sh;
        logic [15:0]   rx;
    } eng_t;

    eng_t q, d;
    logic in_read_window;

    assign in_read_window = q.rd && (q.bitn >= TA_BIT) && (q.bitn <= DATA_LAST);

    always_comb begin
        d = q;
        d.fdone = 1'b0;
        if (!q.active) begin
            if (start) begin
                d.active  = 1'b1;
                d.clk_lvl = 1'b0;
                d.cnt     = '0;
                d.bitn    = '0;
                d.rd      = is_read;
                d.sh      = {32'hFFFF_FFFF, (is_read ? 4'b0110 : 4'b0101), PHY_ADDR, regad,
                             (is_read ? 18'h3FFFF : {2'b10, wdata})};
            end
        end else if (q.cnt == HALF_LAST) begin
            d.cnt     = '0;
            d.clk_lvl = ~q.clk_lvl;
            if (q.clk_lvl) begin
                if (q.rd && q.bitn >= DATA_FIRST && q.bitn <= DATA_LAST)
                    d.rx = {q.rx[14:0], mdio_i};
                if (q.bitn == (q.rd ? RD_END : WR_END)) begin
                    d.active = 1'b0;
                    d.fdone  = 1'b1;
                end else begin
                    d.bitn = q.bitn + 7'd1;
                    d.sh   = {q.sh[62:0], 1'b1};
                end
            end
        end else begin
            d.cnt = q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{active: 1'b0, clk_lvl: 1'b0, rd: 1'b0, fdone: 1'b0,
                   cnt: '0, bitn: '0, sh: '1, rx: '0};
        end else begin
            q <= d;
        end
    end

    assign mdc        = q.clk_lvl;
    assign mdio_o     = q.sh[63];
    assign mdio_oe    = q.active && !in_read_window;
    assign frame_done = q.fdone;
    assign rx_data    = q.rx;
endmodule

// File: rtl/phy_mgmt_master.sv
module phy_mgmt_master
    import mdio_pkg::*;
#(
    parameter int         CLK_HALF      = 40,
    parameter logic [4:0] PHY_ADDR      = 5'h07,
    parameter int         SETTLE_CYCLES = 4000000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [2:0]  req_cmd,
    input  logic [4:0]  req_reg,
    input  logic [15:0] req_wdata,
    input  logic [2:0]  req_mode,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        link_up,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int SW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYCLES - 1);

    typedef enum logic [1:0] {ST_IDLE, ST_FRAME, ST_SETTLE} seq_state_e;

    typedef struct packed {
        seq_state_e  st;
        logic        want_settle;
        logic        was_read;
        logic        was_query;
        logic        done;
        logic        link;
        logic [15:0] rdat;
        logic [SW-1:0] wait_cnt;
    } seq_t;

    seq_t q, d;
    frame_req_t fr;
    logic start;
    logic eng_done;
    logic [15:0] eng_rx;

    mdio_cmd_map u_map (
        .cmd(req_cmd), .regad(req_reg), .wdata(req_wdata), .mode(req_mode), .req(fr)
    );

    mdio_frame_engine #(.CLK_HALF(CLK_HALF), .PHY_ADDR(PHY_ADDR)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .is_read(fr.is_read),
        .regad(fr.regad), .wdata(fr.data), .mdio_i(mdio_i), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .frame_done(eng_done), .rx_data(eng_rx)
    );

    always_comb begin
        d = q;
        d.done = 1'b0;
        start = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid && fr.valid) begin
                    start         = 1'b1;
                    d.st          = ST_FRAME;
                    d.want_settle = fr.settle;
                    d.was_read    = fr.is_read;
                    d.was_query   = fr.query;
                end
            end
            ST_FRAME: begin
                if (eng_done) begin
                    if (q.was_read)  d.rdat = eng_rx;
                    if (q.was_query) d.link = eng_rx[BIT_LINK_OK];
                    if (q.want_settle) begin
                        d.st       = ST_SETTLE;
                        d.wait_cnt = '0;
                    end else begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end
                end
            end
            ST_SETTLE: begin
                if (q.wait_cnt == SETTLE_LAST) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end else begin
                    d.wait_cnt = q.wait_cnt + SW'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, want_settle: 1'b0, was_read: 1'b0, was_query: 1'b0,
                   done: 1'b0, link: 1'b0, rdat: '0, wait_cnt: '0};
        end else begin
            q <= d;
        end
    end

    assign busy    = (q.st != ST_IDLE);
    assign done    = q.done;
    assign rd_data = q.rdat;
    assign link_up = q.link;
endmodule

// File: rtl/phy_mgmt_checker.sv
module phy_mgmt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic [15:0] rd_data
);
    p_mdc_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    p_line_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    p_data_moves_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> !mdc);

    p_enable_moves_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_oe) |-> !mdc);

    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_not_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_rdata_on_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> done);
endmodule

bind phy_mgmt_master phy_mgmt_checker u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_data(rd_data)
);

// File: tb/sim_phy_mgmt_master.sv
module sim_phy_mgmt_master;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int HALF   = 4;
    localparam int SETTLE = 200;
    localparam logic [4:0] PHY = 5'h07;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_cmd = '0;
    logic [4:0] req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic [2:0] req_mode = '0;
    logic busy, done, link_up, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    logic mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    phy_mgmt_master #(.CLK_HALF(HALF), .PHY_ADDR(PHY), .SETTLE_CYCLES(SETTLE)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_reg(req_reg), .req_wdata(req_wdata), .req_mode(req_mode),
        .busy(busy), .done(done), .rd_data(rd_data), .link_up(link_up),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model: records each rising management clock edge, answers reads
    logic clr = 1'b0;
    int r = 0;
    logic [64:0] rec_o, rec_oe;
    logic [15:0] phy_data = '0;

    always @(posedge mdc or posedge clr) begin
        if (clr) begin
            r <= 0;
            mdio_i <= 1'b1;
        end else begin
            if (r < 65) begin
                rec_o[r]  <= mdio_o;
                rec_oe[r] <= mdio_oe;
            end
            mdio_i <= (r >= 47 && r <= 62) ? phy_data[62 - r] : 1'b1;
            r <= r + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_bit(int k, bit rd, logic [4:0] ra, logic [15:0] dt);
        logic [3:0] op;
        op = rd ? 4'b0110 : 4'b0101;
        if (k < 32) return 1'b1;
        if (k < 36) return op[35 - k];
        if (k < 41) return PHY[40 - k];
        if (k < 46) return ra[45 - k];
        if (rd) return 1'b1;
        if (k == 46) return 1'b1;
        if (k == 47) return 1'b0;
        if (k < 64) return dt[63 - k];
        return 1'b1;
    endfunction

    function automatic logic exp_oe(int k, bit rd);
        return rd ? !(k >= 46 && k <= 62) : 1'b1;
    endfunction

    function automatic logic [15:0] mode_word(logic [2:0] m);
        case (m)
            3'd1: return 16'h0000;
            3'd2: return 16'h0100;
            3'd3: return 16'h2000;
            3'd4: return 16'h2100;
            default: return 16'h1000;
        endcase
    endfunction

    int mdc_err;
    int cyc;

    task automatic run(input logic [2:0] cmd, input logic [4:0] ra, input logic [15:0] wd,
                       input logic [2:0] md, input logic [15:0] pd, input bit inject);
        int run_len;
        logic prev;
        bit seen_hi;
        phy_data = pd;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        req_cmd = cmd; req_reg = ra; req_wdata = wd; req_mode = md; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1; run_len = 1; prev = mdc; seen_hi = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (inject && cyc == 60) begin
                req_cmd = 3'd1; req_reg = 5'h1F; req_wdata = 16'hDEAD; req_valid = 1'b1;
            end else begin
                req_valid = 1'b0;
            end
            if (mdc != prev) begin
                if (prev || seen_hi) if (run_len != HALF) mdc_err++;
                if (prev) seen_hi = 1;
                run_len = 1;
            end else begin
                run_len++;
            end
            prev = mdc;
        end
        req_valid = 1'b0;
    endtask

    task automatic check_frame(input bit rd, input logic [4:0] ra, input logic [15:0] dt,
                               input string req);
        int last;
        int bad;
        last = rd ? 63 : 64;
        bad = 0;
        for (int k = 0; k <= last; k++) begin
            if (rec_oe[k] !== exp_oe(k, rd)) bad++;
            else if (exp_oe(k, rd) && rec_o[k] !== exp_bit(k, rd, ra, dt)) bad++;
        end
        chk(r == last + 1, req, r, last + 1);
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic done_pulse(input string req);
        chk(done && !busy, req, {done, busy}, 2'b10);
        @(negedge clk);
        chk(!done, req, done, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] keep;
        void'($urandom(32'd5123));
        mdc_err = 0;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !mdc && !mdio_oe && !link_up && rd_data == 0, "R1",
            {busy, done, mdc, mdio_oe, link_up}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mdio_oe && rd_data == 0, "R1", {busy, mdio_oe}, 0);

        // R3 directed corner patterns then random writes
        run(3'd1, 5'h00, 16'h0000, 3'd0, 16'h0, 0); check_frame(0, 5'h00, 16'h0000, "R3");
        done_pulse("R11");
        run(3'd1, 5'h1F, 16'hFFFF, 3'd0, 16'h0, 0); check_frame(0, 5'h1F, 16'hFFFF, "R3");
        for (int i = 0; i < 5; i++) begin
            logic [4:0] ra; logic [15:0] wd;
            ra = 5'($urandom); wd = 16'($urandom);
            run(3'd1, ra, wd, 3'd0, 16'h0, 0); check_frame(0, ra, wd, "R3");
            chk(!mdio_oe, "R5", mdio_oe, 0);
        end
        chk(mdc_err == 0, "R2", mdc_err, 0);

        // R4 reads with random PHY answers
        for (int i = 0; i < 6; i++) begin
            logic [4:0] ra; logic [15:0] pd;
            ra = 5'($urandom); pd = (i == 0) ? 16'h8001 : 16'($urandom);
            run(3'd0, ra, 16'h0, 3'd0, pd, 0); check_frame(1, ra, 16'h0, "R4");
            chk(rd_data == pd, "R4", rd_data, pd);
            done_pulse("R11");
        end
        chk(mdc_err == 0, "R2", mdc_err, 0);

        // R11 rd_data held across a write
        keep = rd_data;
        run(3'd1, 5'h05, 16'h1234, 3'd0, 16'hFFFF, 0);
        chk(rd_data == keep, "R11", rd_data, keep);

        // R7 reset with settle
        run(3'd2, 5'h0, 16'h0, 3'd0, 16'h0, 0);
        check_frame(0, 5'h00, 16'h8000, "R7");
        chk(cyc >= 130 * HALF + SETTLE && cyc <= 130 * HALF + SETTLE + 4, "R7",
            cyc, 130 * HALF + SETTLE);

        // R8 link query
        run(3'd3, 5'h0, 16'h0, 3'd0, 16'h7FFF, 0);
        check_frame(1, 5'h01, 16'h0, "R8");
        chk(link_up == 1'b1 && rd_data == 16'h7FFF, "R8", {link_up, rd_data}, 17'h17FFF);
        run(3'd3, 5'h0, 16'h0, 3'd0, 16'hFFFB, 0);
        chk(link_up == 1'b0 && rd_data == 16'hFFFB, "R8", {link_up, rd_data}, 17'h0FFFB);
        run(3'd1, 5'h09, 16'h0004, 3'd0, 16'h0, 0);
        chk(link_up == 1'b0, "R8", link_up, 0);

        // R9 link modes
        for (int m = 0; m < 8; m++) begin
            if (m == 5 || m == 6) continue;
            run(3'd4, 5'h0, 16'h0, 3'(m), 16'h0, 0);
            check_frame(0, 5'h00, mode_word(3'(m)), "R9");
        end

        // R10 request during a frame is ignored
        run(3'd1, 5'h0A, 16'hA5A5, 3'd0, 16'h0, 1);
        check_frame(0, 5'h0A, 16'hA5A5, "R10");
        repeat (200) @(negedge clk);
        chk(!busy && r == 65, "R10", r, 65);

        // R10 unused command codes
        for (int c = 5; c < 8; c++) begin
            clr = 1'b1; @(negedge clk); clr = 1'b0;
            req_cmd = 3'(c); req_valid = 1'b1;
            @(negedge clk); req_valid = 1'b0;
            repeat (40) @(negedge clk);
            chk(!busy && !done && r == 0 && !mdio_oe, "R10", {busy, r[7:0]}, 0);
        end

        chk(mdc_err == 0, "R2", mdc_err, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule